// File: doc/BRIEF.md
# Dual-Clock Flagged Mailbox Pair

This block gives two independently clocked ports a way to hand single words to each other outside the bulk data path. Port A deposits a word in the first mailbox and port B collects it; port B deposits a word in the second mailbox and port A collects it. Each mailbox has an active-low full flag. The flag lives in the clock domain of the writing port. It falls when a word is accepted. It blocks any further deposit until the reading port has fetched the word. The read event reaches the writer's domain through a toggle-and-two-flop synchronizer.

Each port has a mailbox-select input. When the select is high, the transfer goes to the mailbox. When it is low, the transfer belongs to the neighbouring FIFO. In that case the block only raises the matching FIFO strobe, or captures the FIFO output word into the port's output register. The mailbox data width follows the bus width configured for port B. Words that port B stores, and words that port B fetches from the first mailbox, keep only the active low-order lanes; the lanes above are zero.

Top module: `dual_clk_mailbox`

## Requirements
- R1: After its domain reset (synchronous, active low), the first mailbox flag `mb1_full_n` and the second mailbox flag `mb2_full_n` are high, and both `a_dout` and `b_dout` are zero.
- R2: A port A transfer is `a_cs_n`=0 and `a_en`=1 at a `clk_a` rising edge. A port A transfer with `a_wr`=1 and `a_mbsel`=1, made while `mb1_full_n` is high, stores `a_din` in the first mailbox and drives `mb1_full_n` low from that edge.
- R3: While `mb1_full_n` is low, port A mailbox writes leave the stored word unchanged.
- R4: A port B transfer (`b_cs_n`=0, `b_en`=1) with `b_rd`=1 and `b_mbsel`=1 loads the first mailbox word, masked to the bus width, into `b_dout` at that `clk_b` edge. `mb1_full_n` is still low one `clk_a` edge later and has returned high by the fourth `clk_a` edge after that port B edge.
- R5: A port B transfer with `b_rd`=1 and `b_mbsel`=0 raises `b_fifo_rd` during that cycle and loads `fifo_b_q` into `b_dout`. It leaves `mb1_full_n` unchanged.
- R6: The second mailbox mirrors R2 to R4. A port B transfer with `b_rd`=0 and `b_mbsel`=1 stores the word and drives `mb2_full_n` low. Writes are blocked while the flag is low. A port A transfer with `a_wr`=0 and `a_mbsel`=1 loads the stored word into `a_dout` and returns `mb2_full_n` high a few `clk_b` edges later.
- R7: The bus width is selected by `b_size`: 00 gives the full DW bits, 01 the low DW/2 bits and 10 or 11 the low DW/4 bits. The second mailbox stores `b_din` with the upper lanes zeroed. `b_dout` shows the first mailbox with the upper lanes zeroed.
- R8: When `cs_n` is high or `en` is low at an edge, that port changes no flag, no mailbox word and no output register.
- R9: `mb2_rst_n` low at a `clk_b` edge clears the second mailbox word to zero and sets `mb2_full_n` high. The first mailbox and its flag are left alone.
- R10: A port A transfer with `a_wr`=1 and `a_mbsel`=0 raises `a_fifo_wr` during that cycle and does not touch the first mailbox or its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A domain reset, synchronous, active low |
| a_cs_n | input | 1 | Port A select, active low |
| a_en | input | 1 | Port A enable |
| a_wr | input | 1 | Port A direction, 1 = write |
| a_mbsel | input | 1 | Port A mailbox select, 0 = FIFO |
| a_din | input | DW | Port A write data |
| fifo_a_q | input | DW | FIFO output word offered to port A |
| a_dout | output | DW | Port A read register |
| a_fifo_wr | output | 1 | Port A FIFO write strobe |
| mb1_full_n | output | 1 | First mailbox full flag, low = full, clk_a domain |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B domain reset, synchronous, active low |
| mb2_rst_n | input | 1 | Second mailbox reset, synchronous to clk_b, active low |
| b_size | input | 2 | Port B bus width select |
| b_cs_n | input | 1 | Port B select, active low |
| b_en | input | 1 | Port B enable |
| b_rd | input | 1 | Port B direction, 1 = read |
| b_mbsel | input | 1 | Port B mailbox select, 0 = FIFO |
| b_din | input | DW | Port B write data |
| fifo_b_q | input | DW | FIFO output register word for port B |
| b_dout | output | DW | Port B read register |
| b_fifo_rd | output | 1 | Port B FIFO read strobe |
| mb2_full_n | output | 1 | Second mailbox full flag, low = full, clk_b domain |

## Verification
The bench attempts a second deposit while a mailbox is still full. A design that does not block it would overwrite the word, and the reader would see the newer value. It samples the first mailbox flag one `clk_a` edge after the port B fetch and again four edges later. A flag cleared too early, or a lost toggle, shows up as a wrong level at one of these points. A deasserted select or enable must leave the flags and output registers untouched, and a FIFO-side access must not disturb a full mailbox. The narrow bus widths and the separate second-mailbox reset are exercised so that leaked upper lanes or a reset that reaches the wrong mailbox produce a mismatch.

// File: rtl/mbx_pkg.sv
// Shared definitions for the dual-clock mailbox pair.
// Assumes: the port B bus width select is static while traffic flows.
package mbx_pkg;
    // Port B bus width selection codes
    typedef enum logic [1:0] {
        BUS_FULL    = 2'b00,
        BUS_HALF    = 2'b01,
        BUS_QUARTER = 2'b10,
        BUS_QTR_ALT = 2'b11
    } bus_width_e;
endpackage

// File: rtl/mbx_toggle_sync.sv
// Carries a one-cycle event from a source clock to a destination clock.
// The source flips a toggle bit; the destination passes it through STAGES
// flops and pulses once per observed change.
// Assumes: source events are spaced wider than STAGES+1 destination cycles.
module mbx_toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_evt,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    logic              tog_q;
    logic [STAGES:0]   shift_q;

    // Flip the toggle on every source event
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) tog_q <= 1'b0;
        else            tog_q <= tog_q ^ src_evt;
    end

    // Resample the toggle and keep one extra flop for edge detection
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) shift_q <= '0;
        else            shift_q <= {shift_q[STAGES-1:0], tog_q};
    end

    assign dst_pulse = shift_q[STAGES] ^ shift_q[STAGES-1];
endmodule

// File: rtl/mbx_slot.sv
// One mailbox: a data word and its active-low full flag, both kept in the
// writer's clock domain. A write is accepted only while the flag is high.
// A clear pulse, already synchronized into this domain, raises the flag.
// Assumes: the reader samples data_q only while the flag is low.
module mbx_slot #(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    input  logic          clr_pulse,
    output logic [DW-1:0] data_q,
    output logic          full_n
);
    // Accept a word into an empty slot; else honour a clear from the reader
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            full_n <= 1'b1;
        end else if (wr_req && full_n) begin
            data_q <= wr_data;
            full_n <= 1'b0;
        end else if (clr_pulse) begin
            full_n <= 1'b1;
        end
    end
endmodule

// File: rtl/dual_clk_mailbox.sv
// Two flagged mailboxes between independently clocked ports A and B.
// Mailbox 1 is written from A and read from B; mailbox 2 goes the other way.
// Read events cross to the writer domain through toggle synchronizers.
// FIFO-side accesses only raise strobes or capture the FIFO word.
// Assumes: rst_a_n and rst_b_n are asserted together for several cycles
// of both clocks; b_size is static during traffic.
module dual_clk_mailbox
    import mbx_pkg::*;
#(
    parameter int DW          = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk_a,
    input  logic          rst_a_n,
    input  logic          a_cs_n,
    input  logic          a_en,
    input  logic          a_wr,
    input  logic          a_mbsel,
    input  logic [DW-1:0] a_din,
    input  logic [DW-1:0] fifo_a_q,
    output logic [DW-1:0] a_dout,
    output logic          a_fifo_wr,
    output logic          mb1_full_n,
    input  logic          clk_b,
    input  logic          rst_b_n,
    input  logic          mb2_rst_n,
    input  logic [1:0]    b_size,
    input  logic          b_cs_n,
    input  logic          b_en,
    input  logic          b_rd,
    input  logic          b_mbsel,
    input  logic [DW-1:0] b_din,
    input  logic [DW-1:0] fifo_b_q,
    output logic [DW-1:0] b_dout,
    output logic          b_fifo_rd,
    output logic          mb2_full_n
);
    localparam int HALF_W    = DW / 2;
    localparam int QUARTER_W = DW / 4;

    // Lane mask for the selected port B bus width
    function automatic logic [DW-1:0] lane_mask(input logic [1:0] sz);
        logic [DW-1:0] m;
        int            w;
        case (bus_width_e'(sz))
            BUS_FULL: w = DW;
            BUS_HALF: w = HALF_W;
            default:  w = QUARTER_W;
        endcase
        for (int i = 0; i < DW; i++) m[i] = (i < w);
        return m;
    endfunction

    logic          a_xfer, a_mb1_wr, a_mb2_rd, a_rd_any;
    logic          b_xfer, b_mb2_wr, b_mb1_rd, b_rd_any;
    logic          clr_mb1, clr_mb2;
    logic          mb2_rst_all_n;
    logic [DW-1:0] b_mask;
    logic [DW-1:0] mb1_q, mb2_q;

    // Port qualifiers
    assign a_xfer    = !a_cs_n && a_en;
    assign a_mb1_wr  = a_xfer && a_wr && a_mbsel;
    assign a_mb2_rd  = a_xfer && !a_wr && a_mbsel;
    assign a_rd_any  = a_xfer && !a_wr;
    assign a_fifo_wr = a_xfer && a_wr && !a_mbsel;

    assign b_xfer    = !b_cs_n && b_en;
    assign b_mb2_wr  = b_xfer && !b_rd && b_mbsel;
    assign b_mb1_rd  = b_xfer && b_rd && b_mbsel;
    assign b_rd_any  = b_xfer && b_rd;
    assign b_fifo_rd = b_xfer && b_rd && !b_mbsel;

    assign b_mask        = lane_mask(b_size);
    assign mb2_rst_all_n = rst_b_n && mb2_rst_n;

    mbx_slot #(.DW(DW)) u_slot1 (
        .clk       (clk_a),
        .rst_n     (rst_a_n),
        .wr_req    (a_mb1_wr),
        .wr_data   (a_din),
        .clr_pulse (clr_mb1),
        .data_q    (mb1_q),
        .full_n    (mb1_full_n)
    );

    mbx_slot #(.DW(DW)) u_slot2 (
        .clk       (clk_b),
        .rst_n     (mb2_rst_all_n),
        .wr_req    (b_mb2_wr),
        .wr_data   (b_din & b_mask),
        .clr_pulse (clr_mb2),
        .data_q    (mb2_q),
        .full_n    (mb2_full_n)
    );

    mbx_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync_b2a (
        .src_clk   (clk_b),
        .src_rst_n (rst_b_n),
        .src_evt   (b_mb1_rd),
        .dst_clk   (clk_a),
        .dst_rst_n (rst_a_n),
        .dst_pulse (clr_mb1)
    );

    mbx_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync_a2b (
        .src_clk   (clk_a),
        .src_rst_n (rst_a_n),
        .src_evt   (a_mb2_rd),
        .dst_clk   (clk_b),
        .dst_rst_n (rst_b_n),
        .dst_pulse (clr_mb2)
    );

    // Port A read register: mailbox 2 or the FIFO word
    always_ff @(posedge clk_a) begin
        if (!rst_a_n)      a_dout <= '0;
        else if (a_rd_any) a_dout <= a_mbsel ? mb2_q : fifo_a_q;
    end

    // Port B read register: masked mailbox 1 or the FIFO output word
    always_ff @(posedge clk_b) begin
        if (!rst_b_n)      b_dout <= '0;
        else if (b_rd_any) b_dout <= b_mbsel ? (mb1_q & b_mask) : fifo_b_q;
    end
endmodule

// File: rtl/mbx_checker.sv
// Property checker for dual_clk_mailbox, bound to every instance.
// Assumes: it sees the top's ports and the two internal mailbox words.
module mbx_checker #(
    parameter int DW = 36
) (
    input logic          clk_a,
    input logic          rst_a_n,
    input logic          a_cs_n,
    input logic          a_en,
    input logic          a_wr,
    input logic          a_mbsel,
    input logic [DW-1:0] a_din,
    input logic [DW-1:0] a_dout,
    input logic          mb1_full_n,
    input logic          clk_b,
    input logic          rst_b_n,
    input logic          mb2_rst_n,
    input logic          b_cs_n,
    input logic          b_en,
    input logic          b_rd,
    input logic          b_mbsel,
    input logic [DW-1:0] fifo_b_q,
    input logic [DW-1:0] b_dout,
    input logic          mb2_full_n,
    input logic [DW-1:0] mb1_q,
    input logic [DW-1:0] mb2_q
);
    p_reset_state_r1: assert property (@(posedge clk_a)
        !rst_a_n |=> (mb1_full_n && a_dout == '0));

    p_accept_sets_flag_r2: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (!a_cs_n && a_en && a_wr && a_mbsel && mb1_full_n)
        |=> (!mb1_full_n && mb1_q == $past(a_din)));

    p_flag_falls_on_write_r2: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        $fell(mb1_full_n) |-> $past(!a_cs_n && a_en && a_wr && a_mbsel));

    p_full_blocks_write_r3: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        !mb1_full_n |=> $stable(mb1_q));

    p_fifo_read_r5: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (!b_cs_n && b_en && b_rd && !b_mbsel) |=> (b_dout == $past(fifo_b_q)));

    p_idle_holds_r8: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (b_cs_n || !b_en) |=> $stable(b_dout));

    p_mb2_sets_flag_r6: assert property (@(posedge clk_b) disable iff (!rst_b_n || !mb2_rst_n)
        (!b_cs_n && b_en && !b_rd && b_mbsel && mb2_full_n) |=> !mb2_full_n);

    p_mb2_blocks_r6: assert property (@(posedge clk_b) disable iff (!rst_b_n || !mb2_rst_n)
        !mb2_full_n |=> $stable(mb2_q));

    p_mb2_reset_r9: assert property (@(posedge clk_b)
        !mb2_rst_n |=> (mb2_full_n && mb2_q == '0));
endmodule

bind dual_clk_mailbox mbx_checker #(.DW(DW)) u_mbx_checker (.*);

// File: tb/dual_clk_mailbox_tb.sv
module dual_clk_mailbox_tb;
    localparam int DW           = 36;
    localparam int CLK_A_PERIOD = 10;
    localparam int CLK_B_PERIOD = 14;

    logic          clk_a = 1'b0, clk_b = 1'b0;
    logic          rst_a_n = 1'b0, rst_b_n = 1'b0, mb2_rst_n = 1'b1;
    logic          a_cs_n = 1'b1, a_en = 1'b0, a_wr = 1'b0, a_mbsel = 1'b0;
    logic          b_cs_n = 1'b1, b_en = 1'b0, b_rd = 1'b0, b_mbsel = 1'b0;
    logic [1:0]    b_size = 2'b00;
    logic [DW-1:0] a_din = '0, b_din = '0, fifo_a_q = '0, fifo_b_q = '0;
    logic [DW-1:0] a_dout, b_dout;
    logic          a_fifo_wr, b_fifo_rd, mb1_full_n, mb2_full_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_A_PERIOD/2) clk_a = ~clk_a;
    always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

    dual_clk_mailbox #(.DW(DW)) u_dut (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] lanes(input logic [1:0] sz, input logic [DW-1:0] d);
        logic [DW-1:0] r;
        int w;
        w = (sz == 2'b00) ? DW : (sz == 2'b01) ? DW/2 : DW/4;
        for (int i = 0; i < DW; i++) r[i] = (i < w) ? d[i] : 1'b0;
        return r;
    endfunction

    // One port A cycle; strb is the expected a_fifo_wr level
    task automatic a_op(input logic cs_n, input logic en, input logic wr,
                        input logic mbsel, input logic [DW-1:0] d, input logic strb);
        @(posedge clk_a); #1;
        a_cs_n = cs_n; a_en = en; a_wr = wr; a_mbsel = mbsel; a_din = d;
        #1 check("R10 a_fifo_wr strobe", 64'(a_fifo_wr), 64'(strb));
        @(posedge clk_a); #1;
        a_cs_n = 1'b1; a_en = 1'b0;
    endtask

    // One port B cycle; strb is the expected b_fifo_rd level
    task automatic b_op(input logic cs_n, input logic en, input logic rd,
                        input logic mbsel, input logic [DW-1:0] d, input logic strb);
        @(posedge clk_b); #1;
        b_cs_n = cs_n; b_en = en; b_rd = rd; b_mbsel = mbsel; b_din = d;
        #1 check("R5 b_fifo_rd strobe", 64'(b_fifo_rd), 64'(strb));
        @(posedge clk_b); #1;
        b_cs_n = 1'b1; b_en = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(posedge clk_a);
        repeat (6) @(posedge clk_b);
        #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_A_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] m1, m2, ea, eb, d, fa, fb;
        logic          f1, f2;
        void'($urandom(32'h1234_abcd));

        repeat (5) @(posedge clk_b);
        #1 rst_a_n = 1'b1; rst_b_n = 1'b1;
        #1;
        check("R1 mb1_full_n after reset", 64'(mb1_full_n), 64'd1);
        check("R1 mb2_full_n after reset", 64'(mb2_full_n), 64'd1);
        check("R1 a_dout after reset", 64'(a_dout), 64'd0);
        check("R1 b_dout after reset", 64'(b_dout), 64'd0);

        // R2 / R3 / R4: deposit, blocked deposit, fetch and flag recovery
        a_op(1'b0, 1'b1, 1'b1, 1'b1, 36'h1_2345_6789, 1'b0);
        check("R2 mb1 flag low after write", 64'(mb1_full_n), 64'd0);
        a_op(1'b0, 1'b1, 1'b1, 1'b1, 36'hF_0F0F_0F0F, 1'b0);
        settle();
        check("R3 flag stays low", 64'(mb1_full_n), 64'd0);
        b_op(1'b0, 1'b1, 1'b1, 1'b1, '0, 1'b0);
        @(posedge clk_a); #1;
        check("R4 flag still low one clk_a edge after fetch", 64'(mb1_full_n), 64'd0);
        repeat (3) @(posedge clk_a); #1;
        check("R4 flag high within four clk_a edges", 64'(mb1_full_n), 64'd1);
        check("R3 blocked write left first word", 64'(b_dout), 64'h1_2345_6789);

        // R8: deselected or disabled cycles do nothing
        a_op(1'b1, 1'b1, 1'b1, 1'b1, 36'hA_AAAA_AAAA, 1'b0);
        a_op(1'b0, 1'b0, 1'b1, 1'b1, 36'hB_BBBB_BBBB, 1'b0);
        settle();
        check("R8 ignored writes keep mb1 flag high", 64'(mb1_full_n), 64'd1);
        fifo_b_q = 36'h5_5555_5555;
        b_op(1'b1, 1'b1, 1'b1, 1'b0, '0, 1'b0);
        check("R8 deselected read holds b_dout", 64'(b_dout), 64'h1_2345_6789);
        b_op(1'b0, 1'b1, 1'b1, 1'b1, '0, 1'b0);
        check("R8 mailbox word unchanged", 64'(b_dout), 64'h1_2345_6789);
        settle();

        // R5: FIFO read while mailbox 1 is full
        a_op(1'b0, 1'b1, 1'b1, 1'b1, 36'h0_CAFE_0001, 1'b0);
        fifo_b_q = 36'h7_7777_0007;
        b_op(1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b1);
        check("R5 b_dout takes FIFO word", 64'(b_dout), 64'h7_7777_0007);
        settle();
        check("R5 mb1 flag untouched by FIFO read", 64'(mb1_full_n), 64'd0);

        // R10: FIFO write from A leaves mailbox 1 alone
        a_op(1'b0, 1'b1, 1'b1, 1'b0, 36'h9_9999_9999, 1'b1);
        b_op(1'b0, 1'b1, 1'b1, 1'b1, '0, 1'b0);
        check("R10 mailbox word intact", 64'(b_dout), 64'h0_CAFE_0001);
        settle();

        // R6: mailbox 2 round trip
        b_op(1'b0, 1'b1, 1'b0, 1'b1, 36'hA_BCDE_F012, 1'b0);
        check("R6 mb2 flag low after write", 64'(mb2_full_n), 64'd0);
        b_op(1'b0, 1'b1, 1'b0, 1'b1, 36'h1_1111_1111, 1'b0);
        a_op(1'b0, 1'b1, 1'b0, 1'b1, '0, 1'b0);
        check("R6 a_dout shows first word", 64'(a_dout), 64'hA_BCDE_F012);
        settle();
        check("R6 mb2 flag high after A fetch", 64'(mb2_full_n), 64'd1);

        // R7: narrow bus widths
        b_size = 2'b01;
        b_op(1'b0, 1'b1, 1'b0, 1'b1, 36'hF_FFFF_FFFF, 1'b0);
        a_op(1'b0, 1'b1, 1'b0, 1'b1, '0, 1'b0);
        check("R7 half width stored in mb2", 64'(a_dout), 64'h0_0003_FFFF);
        settle();
        b_size = 2'b10;
        a_op(1'b0, 1'b1, 1'b1, 1'b1, 36'hF_FFFF_FFFF, 1'b0);
        b_op(1'b0, 1'b1, 1'b1, 1'b1, '0, 1'b0);
        check("R7 quarter width on b_dout", 64'(b_dout), 64'h0_0000_01FF);
        settle();
        b_size = 2'b00;

        // R9: separate reset of mailbox 2
        b_op(1'b0, 1'b1, 1'b0, 1'b1, 36'h3_3333_3333, 1'b0);
        a_op(1'b0, 1'b1, 1'b1, 1'b1, 36'h4_4444_4444, 1'b0);
        @(posedge clk_b); #1 mb2_rst_n = 1'b0;
        @(posedge clk_b); #1 mb2_rst_n = 1'b1;
        check("R9 mb2 flag high after its reset", 64'(mb2_full_n), 64'd1);
        check("R9 mb1 flag untouched", 64'(mb1_full_n), 64'd0);
        a_op(1'b0, 1'b1, 1'b0, 1'b1, '0, 1'b0);
        check("R9 mb2 word cleared", 64'(a_dout), 64'd0);
        b_op(1'b0, 1'b1, 1'b1, 1'b1, '0, 1'b0);
        check("R9 mb1 word survived", 64'(b_dout), 64'h4_4444_4444);
        settle();

        // Random traffic against a bench model
        m1 = 36'h4_4444_4444; m2 = '0; f1 = 1'b1; f2 = 1'b1;
        ea = a_dout; eb = b_dout;
        for (int it = 0; it < 80; it++) begin
            logic port, cs_n, en, dir, mbsel, valid;
            if (it % 10 == 0) b_size = 2'($urandom % 4);
            port  = 1'($urandom % 2);
            cs_n  = ($urandom % 4 == 0);
            en    = ($urandom % 4 != 0);
            dir   = 1'($urandom % 2);
            mbsel = 1'($urandom % 2);
            d     = {4'($urandom), 32'($urandom)};
            fa    = {4'($urandom), 32'($urandom)};
            fb    = {4'($urandom), 32'($urandom)};
            fifo_a_q = fa; fifo_b_q = fb;
            valid = !cs_n && en;
            if (port == 1'b0) begin
                a_op(cs_n, en, dir, mbsel, d, valid && dir && !mbsel);
                if (valid && dir && mbsel && f1) begin m1 = d; f1 = 1'b0; end
                if (valid && !dir) begin
                    ea = mbsel ? m2 : fa;
                    if (mbsel) f2 = 1'b1;
                end
            end else begin
                b_op(cs_n, en, dir, mbsel, d, valid && dir && !mbsel);
                if (valid && dir) begin
                    eb = mbsel ? lanes(b_size, m1) : fb;
                    if (mbsel) f1 = 1'b1;
                end
                if (valid && !dir && mbsel && f2) begin m2 = lanes(b_size, d); f2 = 1'b0; end
            end
            settle();
            check("R2 random mb1 flag", 64'(mb1_full_n), 64'(f1));
            check("R6 random mb2 flag", 64'(mb2_full_n), 64'(f2));
            check("R6 random a_dout", 64'(a_dout), 64'(ea));
            check("R4 random b_dout", 64'(b_dout), 64'(eb));
        end
        finish_run();
    end
endmodule